// File: doc/BRIEF.md
# SPI Digital Potentiometer Controller

This block is the digital core of a single-channel digital potentiometer. An SPI target port lets a host read and write three registers: a 7-bit wiper code that drives the tap select, a 7-bit initial-value word that stands for the non-volatile cell, and an 8-bit control register. The analog resistor array takes the tap code and a shutdown line from this block. The open-drain serial output is shown as a pull-low request: the pad drives low while it is 1 and releases otherwise.

After power-up the wiper sits at mid-scale. When the non-volatile store reports that it can be read reliably, the wiper is loaded once from the stored initial value. Shutdown is requested by the active-low pin or by a control bit. While it is active the array ends are opened and the tap is parked at code 0 (ground side). The wiper register keeps its value and all registers stay accessible over SPI. The serial pins are oversampled by the system clock, so SCK must run well below the system clock rate.

Top module: `spi_pot_core`

## Requirements
- R1: After reset the tap output is 40h, the array shutdown output is 0 (with the shutdown pin high), the serial output is released, the busy flag is 0 and the non-volatile word equals the IVR_INIT parameter.
- R2: The first cycle in which nv_ready is high copies the non-volatile word into the wiper. Later changes of nv_ready never reload it.
- R3: A frame is 16 bits, MSB first, sampled on SCK rising edges while chip select is low: opcode[15:12] (0011 write, 0010 read), address[11:8], data[7:0]. A write takes effect when chip select rises.
- R4: A write to address 0 loads data[6:0] into both the wiper and the non-volatile word. Tap code 00h is the ground end and 7Fh the supply end.
- R5: A write to address 0 raises nv_busy for NV_CYCLES clocks. A write to address 0 that completes while nv_busy is high changes nothing.
- R6: A read returns {0, wiper} for address 0 and the control register for address 2. Bits go out MSB first on the serial output, starting at the SCK falling edge after the 8th rising edge, so the host samples data bit 7 on the 9th rising edge.
- R7: A frame with an opcode other than 0011 or 0010, an address other than 0 or 2, or a bit count other than 16 when chip select rises changes no register. A read of an invalid address leaves the output released (reads as all ones).
- R8: The serial output is never requested low while chip select is high.
- R9: Until chip select has gone from high to low once after reset, no frame is accepted.
- R10: Effective shutdown is the OR of shdn_n low and control bit 6. While it is active, array_off is 1 and tap_sel is 0.
- R11: Shutdown does not change the wiper. Registers can be read and written during shutdown, and when shutdown ends the tap shows the wiper value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| sck | input | 1 | SPI serial clock |
| csn | input | 1 | SPI chip select, active low |
| sdi | input | 1 | SPI serial data in |
| shdn_n | input | 1 | Shutdown request pin, active low |
| nv_ready | input | 1 | Non-volatile store can be read reliably |
| tap_sel | output | 7 | Tap select code for the resistor array |
| array_off | output | 1 | Open the array ends and ground the wiper |
| sdo_low | output | 1 | Open-drain request: 1 drives the serial output low |
| nv_data | output | 7 | Word held in the non-volatile store |
| nv_busy | output | 1 | Non-volatile update in progress |

## Verification
A wrong wiper or control value shows on tap_sel or array_off about a dozen clocks after chip select rises, and it is checked after every frame. A corrupted bit counter or shift register shows up as a write that lands at the wrong place, or as read data shifted by one bit in the next read frame. A stuck busy counter blocks the next wiper write, and a missed reload leaves tap_sel at 40h once nv_ready has risen. Random frames are mixed with pin shutdowns so that a mismatch appears within one frame of the faulty step.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int OP_W     = 4;
    localparam int ADR_W    = 4;
    localparam int DAT_W    = 8;
    localparam int WIPER_W  = 7;
    localparam int HDR_W    = OP_W + ADR_W;
    localparam int FRAME_W  = HDR_W + DAT_W;
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int SHDN_BIT = 6;

    localparam logic [OP_W-1:0]  OP_WRITE  = 4'b0011;
    localparam logic [OP_W-1:0]  OP_READ   = 4'b0010;
    localparam logic [ADR_W-1:0] ADR_WIPER = 4'd0;
    localparam logic [ADR_W-1:0] ADR_CTRL  = 4'd2;

    typedef struct packed {
        logic               sck_p;
        logic               csn_p;
        logic               open;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic [DAT_W-1:0]   tx;
        logic               rdok;
        logic               drv;
        logic               stb;
    } frame_st_t;

    function automatic logic addr_ok(input logic [ADR_W-1:0] a);
        return (a == ADR_WIPER) || (a == ADR_CTRL);
    endfunction
endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] s1_q;
    logic [N-1:0] s2_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[i] <= RST_VAL[i];
                s2_q[i] <= RST_VAL[i];
            end else begin
                s1_q[i] <= din[i];
                s2_q[i] <= s1_q[i];
            end
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/pot_frame.sv
module pot_frame
    import pot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_s,
    input  logic             csn_s,
    input  logic             sdi_s,
    input  logic [DAT_W-1:0] rd_data,
    output logic [ADR_W-1:0] rd_addr,
    output logic             wr_stb,
    output logic [ADR_W-1:0] wr_addr,
    output logic [DAT_W-1:0] wr_data,
    output logic             sdo_low
);
    localparam int OP_LO = ADR_W + DAT_W;

    frame_st_t q, d;
    logic [FRAME_W-1:0] shifted;
    logic [OP_W-1:0]    hdr_op;
    logic rise, fall, cs_fall, cs_rise;

    always_comb begin
        d        = q;
        d.sck_p  = sck_s;
        d.csn_p  = csn_s;
        d.stb    = 1'b0;
        shifted  = {q.sh[FRAME_W-2:0], sdi_s};
        rd_addr  = shifted[ADR_W-1:0];
        hdr_op   = shifted[HDR_W-1:ADR_W];
        rise     = sck_s & ~q.sck_p;
        fall     = ~sck_s & q.sck_p;
        cs_fall  = ~csn_s & q.csn_p;
        cs_rise  = csn_s & ~q.csn_p;

        if (cs_fall) begin
            d.open = 1'b1;
            d.cnt  = '0;
            d.drv  = 1'b0;
            d.rdok = 1'b0;
        end else if (csn_s) begin
            d.drv = 1'b0;
            if (cs_rise && q.open && q.cnt == CNT_W'(FRAME_W)
                && q.sh[FRAME_W-1:OP_LO] == OP_WRITE
                && addr_ok(q.sh[OP_LO-1:DAT_W])) begin
                d.stb = 1'b1;
            end
        end else if (q.open) begin
            if (rise && q.cnt != CNT_W'(FRAME_W + 1)) begin
                d.cnt = q.cnt + 1'b1;
                d.sh  = shifted;
                if (q.cnt == CNT_W'(HDR_W - 1)) begin
                    d.rdok = (hdr_op == OP_READ) && addr_ok(rd_addr);
                    d.tx   = rd_data;
                end
            end else if (fall) begin
                if (q.cnt == CNT_W'(HDR_W) && q.rdok) begin
                    d.drv = 1'b1;
                end else if (q.drv) begin
                    d.tx = {q.tx[DAT_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_stb  = q.stb;
    assign wr_addr = q.sh[OP_LO-1:DAT_W];
    assign wr_data = q.sh[DAT_W-1:0];
    assign sdo_low = q.drv & ~q.tx[DAT_W-1] & ~csn_s;

    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |-> !sdo_low);
    p_locked_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(q.open));
    p_full_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(q.cnt) == CNT_W'(FRAME_W)));
endmodule

// File: rtl/pot_regs.sv
module pot_regs
    import pot_pkg::*;
#(
    parameter logic [WIPER_W-1:0] IVR_INIT  = 7'h25,
    parameter int                 NV_CYCLES = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nv_ready,
    input  logic               wr_stb,
    input  logic [ADR_W-1:0]   wr_addr,
    input  logic [DAT_W-1:0]   wr_data,
    input  logic [ADR_W-1:0]   rd_addr,
    output logic [DAT_W-1:0]   rd_data,
    output logic [WIPER_W-1:0] wiper,
    output logic               ctrl_shdn,
    output logic [WIPER_W-1:0] nv_data,
    output logic               nv_busy
);
    localparam int BUSY_W = $clog2(NV_CYCLES + 1);
    localparam logic [WIPER_W-1:0] MID_CODE = WIPER_W'(1) << (WIPER_W - 1);

    typedef struct packed {
        logic [WIPER_W-1:0] wiper;
        logic [WIPER_W-1:0] ivr;
        logic [DAT_W-1:0]   ctrl;
        logic               loaded;
        logic [BUSY_W-1:0]  busy_cnt;
    } regs_st_t;

    regs_st_t q, d;

    always_comb begin
        d = q;
        if (q.busy_cnt != '0) begin
            d.busy_cnt = q.busy_cnt - 1'b1;
        end
        if (!q.loaded && nv_ready) begin
            d.wiper  = q.ivr;
            d.loaded = 1'b1;
        end
        if (wr_stb) begin
            if (wr_addr == ADR_WIPER) begin
                if (q.busy_cnt == '0) begin
                    d.wiper    = wr_data[WIPER_W-1:0];
                    d.ivr      = wr_data[WIPER_W-1:0];
                    d.busy_cnt = BUSY_W'(NV_CYCLES);
                end
            end else if (wr_addr == ADR_CTRL) begin
                d.ctrl = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.wiper    <= MID_CODE;
            q.ivr      <= IVR_INIT;
            q.ctrl     <= '0;
            q.loaded   <= 1'b0;
            q.busy_cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data   = (rd_addr == ADR_CTRL) ? q.ctrl
                                              : {{(DAT_W-WIPER_W){1'b0}}, q.wiper};
    assign wiper     = q.wiper;
    assign ctrl_shdn = q.ctrl[SHDN_BIT];
    assign nv_data   = q.ivr;
    assign nv_busy   = (q.busy_cnt != '0);

    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == ADR_WIPER && nv_busy) |=> $stable(q.ivr));
    p_reload_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.loaded) |-> (q.wiper == q.ivr));
    p_ctrl_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == ADR_CTRL) |=> (q.ctrl == $past(wr_data)));
    p_wiper_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && q.loaded) |=> $stable(q.wiper));
endmodule

// File: rtl/spi_pot_core.sv
module spi_pot_core
    import pot_pkg::*;
#(
    parameter logic [WIPER_W-1:0] IVR_INIT  = 7'h25,
    parameter int                 NV_CYCLES = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               csn,
    input  logic               sdi,
    input  logic               shdn_n,
    input  logic               nv_ready,
    output logic [WIPER_W-1:0] tap_sel,
    output logic               array_off,
    output logic               sdo_low,
    output logic [WIPER_W-1:0] nv_data,
    output logic               nv_busy
);
    logic [2:0]         pins_s;
    logic [ADR_W-1:0]   rd_addr, wr_addr;
    logic [DAT_W-1:0]   rd_data, wr_data;
    logic               wr_stb, ctrl_shdn, shut;
    logic [WIPER_W-1:0] wiper;

    pot_sync #(.N(3), .RST_VAL(3'b000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck, csn, sdi}),
        .dout  (pins_s)
    );

    pot_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[2]),
        .csn_s   (pins_s[1]),
        .sdi_s   (pins_s[0]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo_low (sdo_low)
    );

    pot_regs #(.IVR_INIT(IVR_INIT), .NV_CYCLES(NV_CYCLES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_ready  (nv_ready),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wiper     (wiper),
        .ctrl_shdn (ctrl_shdn),
        .nv_data   (nv_data),
        .nv_busy   (nv_busy)
    );

    assign shut      = ~shdn_n | ctrl_shdn;
    assign array_off = shut;
    assign tap_sel   = shut ? '0 : wiper;

    p_pin_shutdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> (array_off && tap_sel == '0));
    p_tap_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!array_off && $past(!array_off) && !$past(wr_stb)) |-> $stable(tap_sel) || $rose(u_regs.q.loaded));
endmodule

// File: tb/spi_pot_core_test.sv
`timescale 1ns/1ps
module spi_pot_core_test;
    localparam logic [6:0] IVR0 = 7'h25;
    localparam int         NVC  = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b0, sdi = 1'b0, shdn_n = 1'b1, nv_ready = 1'b0;
    logic [6:0] tap_sel, nv_data;
    logic array_off, sdo_low, nv_busy;

    int total = 0;
    int bad = 0;
    logic [6:0] m_wip, m_ivr;
    logic [7:0] m_ctrl;

    always #4 clk = ~clk;

    spi_pot_core #(.IVR_INIT(IVR0), .NV_CYCLES(NVC)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .sdi(sdi),
        .shdn_n(shdn_n), .nv_ready(nv_ready), .tap_sel(tap_sel),
        .array_off(array_off), .sdo_low(sdo_low), .nv_data(nv_data),
        .nv_busy(nv_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_shut();
        return !shdn_n || m_ctrl[6];
    endfunction

    function automatic logic [6:0] exp_tap();
        return exp_shut() ? 7'h00 : m_wip;
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a == 4'd0) return {1'b0, m_wip};
        if (a == 4'd2) return m_ctrl;
        return 8'hFF;
    endfunction

    task automatic xfer(input logic [15:0] w, input int nb, output logic [7:0] rd);
        csn = 1'b0;
        rd = 8'h00;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            repeat (6) @(negedge clk);
            if (i >= 8 && i < 16) rd = {rd[6:0], ~sdo_low};
            sck = 1'b1;
            repeat (6) @(negedge clk);
            sck = 1'b0;
        end
        repeat (6) @(negedge clk);
        csn = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 idle release", sdo_low, 1'b0);
        repeat (8) @(negedge clk);
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] v);
        if (a == 4'd0) begin m_wip = v[6:0]; m_ivr = v[6:0]; end
        else if (a == 4'd2) m_ctrl = v;
    endtask

    task automatic check_outs(input string req);
        check(req, tap_sel, exp_tap());
        check(req, array_off, exp_shut());
        check(req, nv_data, m_ivr);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        void'($urandom(32'd4242));
        m_wip = 7'h40; m_ivr = IVR0; m_ctrl = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tap", tap_sel, 7'h40);
        check("R1 off", array_off, 1'b0);
        check("R1 sdo", sdo_low, 1'b0);
        check("R1 busy", nv_busy, 1'b0);
        check("R1 nv", nv_data, IVR0);

        // R9 frame with chip select low since reset is ignored
        xfer({4'b0011, 4'd0, 8'h11}, 16, rd);
        check("R9 locked tap", tap_sel, 7'h40);
        check("R9 locked nv", nv_data, IVR0);

        // R2 reload
        nv_ready = 1'b1;
        repeat (3) @(negedge clk);
        m_wip = IVR0;
        check("R2 reload", tap_sel, IVR0);

        // R3 R4 write wiper
        xfer({4'b0011, 4'd0, 8'h33}, 16, rd);
        model_write(4'd0, 8'h33);
        check_outs("R4 write");
        // R5 busy and ignored second write
        check("R5 busy", nv_busy, 1'b1);
        xfer({4'b0011, 4'd0, 8'h0A}, 16, rd);
        check_outs("R5 busy ignore");
        while (nv_busy) @(negedge clk);
        // R2 no second reload
        nv_ready = 1'b0;
        repeat (3) @(negedge clk);
        nv_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 once", tap_sel, m_wip);

        // R6 reads
        xfer({4'b0010, 4'd0, 8'h00}, 16, rd);
        check("R6 read wiper", rd, {1'b0, m_wip});
        xfer({4'b0011, 4'd2, 8'h25}, 16, rd);
        model_write(4'd2, 8'h25);
        xfer({4'b0010, 4'd2, 8'h00}, 16, rd);
        check("R6 read ctrl", rd, 8'h25);

        // R7 malformed frames
        xfer({4'b0011, 4'd2, 8'h7F}, 15, rd);
        check_outs("R7 short");
        xfer({4'b0011, 4'd2, 8'h7F}, 17, rd);
        check_outs("R7 long");
        xfer({4'b0011, 4'd1, 8'h40}, 16, rd);
        check_outs("R7 reserved");
        xfer({4'b0111, 4'd2, 8'h40}, 16, rd);
        check_outs("R7 opcode");
        xfer({4'b0010, 4'd1, 8'h00}, 16, rd);
        check("R7 read reserved", rd, 8'hFF);
        xfer({4'b0011, 4'd0, 8'h7F}, 15, rd);
        check("R7 short wiper busy", nv_busy, 1'b0);

        // R10 R11 shutdown by control bit, access during shutdown
        xfer({4'b0011, 4'd2, 8'h40}, 16, rd);
        model_write(4'd2, 8'h40);
        check_outs("R10 ctrl shutdown");
        xfer({4'b0011, 4'd0, 8'h7F}, 16, rd);
        model_write(4'd0, 8'h7F);
        check_outs("R11 write in shutdown");
        xfer({4'b0010, 4'd0, 8'h00}, 16, rd);
        check("R11 read in shutdown", rd, 8'h7F);
        while (nv_busy) @(negedge clk);
        xfer({4'b0011, 4'd2, 8'h00}, 16, rd);
        model_write(4'd2, 8'h00);
        check("R11 restore", tap_sel, 7'h7F);
        // R10 pin shutdown
        shdn_n = 1'b0;
        #1;
        check_outs("R10 pin");
        @(negedge clk);
        shdn_n = 1'b1;
        #1;
        check("R11 pin restore", tap_sel, 7'h7F);
        xfer({4'b0011, 4'd0, 8'h00}, 16, rd);
        model_write(4'd0, 8'h00);
        check_outs("R4 ground end");
        while (nv_busy) @(negedge clk);

        // random mix
        for (int n = 0; n < 60; n++) begin
            int kind;
            logic [3:0] a, op;
            logic [7:0] v;
            kind = $urandom % 8;
            a = 4'($urandom % 4);
            v = 8'($urandom);
            while (nv_busy) @(negedge clk);
            if (kind < 3) begin
                xfer({4'b0011, a, v}, 16, rd);
                model_write(a, v);
                check_outs("R3 random write");
            end else if (kind < 6) begin
                xfer({4'b0010, a, 8'h00}, 16, rd);
                check("R6 random read", rd, exp_read(a));
            end else if (kind == 6) begin
                op = 4'($urandom);
                if (op == 4'b0010 || op == 4'b0011) op = 4'hA;
                xfer({op, a, v}, 16, rd);
                check_outs("R7 random opcode");
            end else begin
                shdn_n = ~shdn_n;
                repeat (2) @(negedge clk);
                check_outs("R10 random pin");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule